// File: doc/BRIEF.md
# Parallel-Jam Serial Shift Register

This block is an eight-stage shift register with two ways of filling it. While the mode input is low, the register advances one place on each rising clock edge. The serial input enters stage 1 and every other stage takes the value of the stage before it. While the mode input is high, every stage is forced straight to its own parallel input bit. This happens asynchronously, whatever the clock is doing, and the forced value follows any change on the parallel inputs for as long as the mode stays high.

Only the last three stages are visible outside the block. They give delays of six, seven and eight clocks from the serial input. A typical use is to capture a parallel word and then stream it out through the stage-8 output, last stage first. Several instances can be chained by feeding one instance's stage-8 output into the next instance's serial input. There is no reset: the contents are undefined until a parallel load, or until eight serial shifts.

Top module: `pj_shift8`

## Requirements
- R1: The serial input enters stage 1. A bit shifted in appears on `tap_m2_o` after 6 rising edges, on `tap_m1_o` after 7, and on `tap_last_o` after 8.
- R2: While `jam_i` is low, each rising clock edge moves stage n-1 into stage n for n = 2..8 and loads `ser_i` into stage 1.
- R3: While `jam_i` is high, stage n equals `par_i[n-1]` without waiting for a clock edge. A change on `par_i` while `jam_i` stays high reaches the stages at once.
- R4: While `jam_i` is high, clock edges and `ser_i` have no effect on the taps.
- R5: When `jam_i` falls, the loaded word stays in place until the next rising clock edge, and that edge performs the first shift.
- R6: With `jam_i` low and no rising clock edge, every stage keeps its value for any length of time, whatever `ser_i` does.
- R7: `tap_m2_o`, `tap_m1_o` and `tap_last_o` show stages 6, 7 and 8, so after a load they equal `par_i[5]`, `par_i[6]` and `par_i[7]`.
- R8: After a load, successive shifts bring the word out of `tap_last_o` in the order `par_i[7]` down to `par_i[0]`. `tap_m1_o` leads this sequence by one clock and `tap_m2_o` leads it by two.
- R9: When `tap_last_o` of one instance drives `ser_i` of a second instance, the pair behaves as one sixteen-stage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock; the register shifts on its rising edge |
| jam_i | input | 1 | Mode: high forces the parallel load, low enables shifting |
| ser_i | input | 1 | Serial data into stage 1 |
| par_i | input | STAGES | Parallel word; bit n-1 loads stage n |
| tap_m2_o | output | 1 | Stage 6 |
| tap_m1_o | output | 1 | Stage 7 |
| tap_last_o | output | 1 | Stage 8 |

## Verification
The hardest cases to reach are those where the clock plays no part: a parallel word changing while the mode is held high, and a register left idle with no clock at all. To reach them, the stimulus gates the block's clock off for a long interval while `ser_i` toggles, and it rewrites `par_i` in the middle of a load with no edge in between. It also keeps the clock running while the mode is high, so that edges which must be ignored really do arrive. A second chained instance shows that a word loaded in one register crosses into the next one bit per clock.

// File: rtl/pj_pkg.sv
package pj_pkg;
    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_JAM   = 1'b1
    } pj_mode_e;
endpackage

// File: rtl/pj_ctrl.sv
module pj_ctrl #(
    parameter int STAGES = 8
) (
    input  logic              load_en_i,
    input  logic [STAGES-1:0] word_i,
    output logic [STAGES-1:0] set_o,
    output logic [STAGES-1:0] clr_o
);
    // Each bit's parallel input picks whether the load acts as a set or a clear on that stage.
    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            set_o[i] = load_en_i &  word_i[i];
            clr_o[i] = load_en_i & ~word_i[i];
        end
    end
endmodule

// File: rtl/pj_cell.sv
module pj_cell (
    input  logic clk_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    // The asynchronous set and clear take priority over the clocked data path.
    always_ff @(posedge clk_i or posedge set_i or posedge clr_i) begin
        if (set_i)      q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
        else            q_o <= d_i;
    end
endmodule

// File: rtl/pj_shift8.sv
module pj_shift8 #(
    parameter int STAGES = 8
) (
    input  logic              clk_i,
    input  logic              jam_i,
    input  logic              ser_i,
    input  logic [STAGES-1:0] par_i,
    output logic              tap_m2_o,
    output logic              tap_m1_o,
    output logic              tap_last_o
);
    import pj_pkg::*;

    localparam int IDX_LAST = STAGES - 1;
    localparam int IDX_M1   = STAGES - 2;
    localparam int IDX_M2   = STAGES - 3;

    typedef struct packed {
        logic [STAGES-1:0] stg;
    } pj_state_t;

    pj_mode_e          mode;
    pj_state_t         state_d;
    pj_state_t         state_q;
    logic [STAGES-1:0] cell_q;
    logic [STAGES-1:0] set_v;
    logic [STAGES-1:0] clr_v;

    assign mode = jam_i ? MODE_JAM : MODE_SHIFT;

    pj_ctrl #(.STAGES(STAGES)) u_ctrl (
        .load_en_i (mode == MODE_JAM),
        .word_i    (par_i),
        .set_o     (set_v),
        .clr_o     (clr_v)
    );

    // Next shift value: stage n takes stage n-1, stage 1 takes the serial input.
    always_comb begin
        state_d.stg = {state_q.stg[STAGES-2:0], ser_i};
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            pj_cell u_cell (
                .clk_i (clk_i),
                .set_i (set_v[g]),
                .clr_i (clr_v[g]),
                .d_i   (state_d.stg[g]),
                .q_o   (cell_q[g])
            );
        end
    endgenerate

    assign state_q.stg = cell_q;

    assign tap_m2_o   = state_q.stg[IDX_M2];
    assign tap_m1_o   = state_q.stg[IDX_M1];
    assign tap_last_o = state_q.stg[IDX_LAST];
endmodule

// File: rtl/pj_shift8_chk.sv
module pj_shift8_chk #(
    parameter int STAGES = 8
) (
    input logic              clk_i,
    input logic              jam_i,
    input logic              ser_i,
    input logic [STAGES-1:0] par_i,
    input logic              tap_m2_o,
    input logic              tap_m1_o,
    input logic              tap_last_o
);
    // The contents are undefined until the first load has been seen at a clock edge.
    logic primed_q = 1'b0;
    always_ff @(posedge clk_i) begin
        if (jam_i) primed_q <= 1'b1;
    end

    // R3, R7: while loading, the taps show the top three parallel bits
    p_jam_taps_r3: assert property (@(posedge clk_i) disable iff (!primed_q)
        jam_i |-> (tap_last_o == par_i[STAGES-1] && tap_m1_o == par_i[STAGES-2]
                   && tap_m2_o == par_i[STAGES-3]));

    // R4: held load with a steady word ignores clock and serial input
    p_jam_ignores_clk_r4: assert property (@(posedge clk_i) disable iff (!primed_q)
        (jam_i && $past(jam_i) && $stable(par_i) && $changed(ser_i) == $changed(ser_i))
        |-> ($stable(tap_last_o) && $stable(tap_m1_o) && $stable(tap_m2_o)));

    // R2: shifting moves each tap one place along
    p_shift_r2: assert property (@(posedge clk_i) disable iff (!primed_q)
        ($past(!jam_i) && !jam_i)
        |-> (tap_last_o == $past(tap_m1_o) && tap_m1_o == $past(tap_m2_o)));

    // R5: after the mode falls, the loaded word is still present at the next edge
    p_fall_hold_r5: assert property (@(posedge clk_i) disable iff (!primed_q)
        ($past(jam_i) && !jam_i)
        |-> (tap_last_o == $past(par_i[STAGES-1]) && tap_m1_o == $past(par_i[STAGES-2])
             && tap_m2_o == $past(par_i[STAGES-3])));
endmodule

bind pj_shift8 pj_shift8_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/pj_shift8_tb.sv
`timescale 1ns/1ps
module pj_shift8_tb;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       gclk;
    logic       jam = 1'b0;
    logic       ser = 1'b0;
    logic [7:0] par = 8'h00;
    logic [7:0] par2 = 8'h00;
    logic       t6, t7, t8, u6, u7, u8;
    bit         mdl [16];
    bit         loaded = 1'b0;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;
    assign gclk = clk & clk_run;

    pj_shift8 #(.STAGES(8)) u_dut (
        .clk_i(gclk), .jam_i(jam), .ser_i(ser), .par_i(par),
        .tap_m2_o(t6), .tap_m1_o(t7), .tap_last_o(t8));

    pj_shift8 #(.STAGES(8)) u_tail (
        .clk_i(gclk), .jam_i(jam), .ser_i(t8), .par_i(par2),
        .tap_m2_o(u6), .tap_m1_o(u7), .tap_last_o(u8));

    // Behavioural sixteen-bit model of the chained pair; index 0 is the first stage.
    always @(posedge gclk) begin
        if (!jam) begin
            for (int i = 15; i > 0; i--) mdl[i] = mdl[i-1];
            mdl[0] = ser;
        end
    end

    task automatic model_load();
        for (int i = 0; i < 8; i++) begin
            mdl[i]   = par[i];
            mdl[i+8] = par2[i];
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (loaded) begin
            check("R2 stage6", t6, mdl[5]);
            check("R2 stage7", t7, mdl[6]);
            check("R2 stage8", t8, mdl[7]);
            check("R9 tail stage6", u6, mdl[13]);
            check("R9 tail stage7", u7, mdl[14]);
            check("R9 tail stage8", u8, mdl[15]);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_load(input logic [7:0] w, input logic [7:0] w2);
        jam = 1'b1; par = w; par2 = w2;
        model_load();
        loaded = 1'b1;
        #1;
        compare_all();
    endtask

    initial begin
        logic [7:0] word;
        logic [7:0] sbits;
        logic h6, h7, h8;

        // R7: load state exposes stages 6, 7, 8 (0xA5: bit7=1, bit6=0, bit5=1)
        @(negedge clk);
        do_load(8'hA5, 8'h5A);
        check("R7 tap stage8", t8, 1'b1);
        check("R7 tap stage7", t7, 1'b0);
        check("R7 tap stage6", t6, 1'b1);

        // R3: change the word while loading, no clock edge in between (0x3C: 0,0,1)
        #0.5;
        par = 8'h3C;
        model_load();
        #0.5;
        check("R3 live stage8", t8, 1'b0);
        check("R3 live stage7", t7, 1'b0);
        check("R3 live stage6", t6, 1'b1);

        // R4: clock edges and serial toggles during a load do nothing
        repeat (4) begin
            @(negedge clk);
            ser = ~ser;
            @(negedge clk);
            check("R4 stage8", t8, 1'b0);
            check("R4 stage7", t7, 1'b0);
            check("R4 stage6", t6, 1'b1);
            compare_all();
        end

        // R5/R8/R1: fresh load, release, stream out while shifting in a serial pattern
        word  = 8'hCA;
        sbits = 8'b1011_0001;
        @(negedge clk);
        do_load(word, 8'hFF);
        @(negedge clk);
        jam = 1'b0;
        #1;
        check("R5 held stage8", t8, word[7]);
        check("R5 held stage7", t7, word[6]);
        check("R5 held stage6", t6, word[5]);
        for (int k = 0; k < 8; k++) begin
            check("R8 stage8 order", t8, word[7-k]);
            if (k < 7) check("R8 stage7 leads by one", t7, word[6-k]);
            if (k < 6) check("R8 stage6 leads by two", t6, word[5-k]);
            if (k == 6) check("R1 six shifts to stage6", t6, sbits[0]);
            if (k == 7) check("R1 seven shifts to stage7", t7, sbits[0]);
            if (k == 1) check("R5 first edge shifts", t8, word[6]);
            ser = sbits[k];
            cyc();
        end
        check("R1 eight shifts to stage8", t8, sbits[0]);
        check("R1 stage7 second bit", t7, sbits[1]);
        check("R1 stage6 third bit", t6, sbits[2]);
        // R9: the tail instance now holds the first instance's loaded word in stages 6..8
        check("R9 tail stage8 from head", u8, word[7]);
        check("R9 tail stage7 from head", u7, word[6]);
        check("R9 tail stage6 from head", u6, word[5]);

        // R6: clock stopped for a long time, serial input toggling
        h6 = t6; h7 = t7; h8 = t8;
        clk_run = 1'b0;
        repeat (40) begin
            @(negedge clk);
            ser = ~ser;
        end
        check("R6 idle stage8", t8, h8);
        check("R6 idle stage7", t7, h7);
        check("R6 idle stage6", t6, h6);
        compare_all();
        @(negedge clk);
        clk_run = 1'b1;

        // R2/R9: mixed serial pattern through the chain
        for (int k = 0; k < 24; k++) begin
            ser = ((k * 7 + 3) % 5) > 1;
            cyc();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule